// File: doc/BRIEF.md
# Microprogram Register Datapath Controller

This block turns one 25-bit microinstruction per clock into the control of a small datapath. That datapath holds eight 8-bit registers with two read ports and one write port. It selects the two operands handed to an external ALU and runs the strobes of an external data bus. The ALU result comes back into the block. On the clock edge that ends the instruction, the result is stored into a register, put on the bus as write data, or both. Sequencing of microinstruction addresses is done elsewhere. Instruction bits 18 to 24 are not used here.

Each cycle, the decoder places the instruction in one of three bus modes. `BUS_IDLE` drives no strobe, `BUS_READ` drives the read strobe and `BUS_WRITE` drives the write strobe. A single output process derives the strobes from the mode with a unique case. There is no sequential control state: each instruction is complete in one cycle. The only storage is the register file.

The same bits 9 to 12 serve as either a 4-bit signed constant or the B read address. For this reason, the B-side write target follows the low three constant bits whenever a constant is in use.

Top module: `mpdc_top`

## Requirements
- R1: A synchronous reset clears all eight registers. Every register then reads as 0x00 through both operand ports.
- R2: With bit 5 at 0, operand B is the register addressed by bits 11:9. With bit 5 at 1, operand B is bits 12:9, sign-extended to 8 bits from bit 12.
- R3: With bit 6 at 0, operand A is the register addressed by bits 15:13. With bit 6 at 1, operand A is the bus read data. The bus address is always the contents of that register.
- R4: With bit 7 at 1, the ALU result is written on the rising edge. The target is the address in bits 11:9 when bit 8 is 1, and bits 15:13 otherwise. With bit 7 at 0, no register changes.
- R5: A register that is written in a cycle still reads its old value during that cycle.
- R6: With bit 16 and bit 17 both at 1, the write strobe is asserted, the bus write data is the ALU result and the read strobe is low.
- R7: With bit 16 at 1 and bit 17 at 0, only the read strobe is asserted. With bit 16 at 0, neither strobe is asserted, whatever bit 17 holds.
- R8: A bus write and a register write in the same instruction both take effect.
- R9: The ALU function output equals bits 4:1 and the flag-store output equals bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| instr_i | input | 25 | Current microinstruction |
| alu_result_i | input | 8 | Result from the external ALU |
| bus_rdata_i | input | 8 | Bus read data |
| alu_a_o | output | 8 | Operand A to the ALU |
| alu_b_o | output | 8 | Operand B to the ALU |
| alu_func_o | output | 4 | ALU function code |
| store_flags_o | output | 1 | Flag-store request |
| bus_addr_o | output | 8 | Bus address (contents of register A) |
| bus_wdata_o | output | 8 | Bus write data |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |

## Verification
Assertions check several properties on every cycle: strobe selection from bits 16 and 17, the sign-extended constant, the bus-sourced operand, passthrough of the function and flag bits, and two register rules. A register read one cycle after an A-target write returns the written result, and it holds steady while nothing writes. Only the bench's instruction sequences show the remaining behaviour. These are writes through the B address, including the constant-aliased target, and old-value reads during a write. They also include bus memory contents after a combined bus and register write, and the clearing of all eight registers by a mid-run reset.

// File: rtl/mpdc_pkg.sv
package mpdc_pkg;
    localparam int INSTR_W   = 25;
    localparam int POS_FLAG  = 0;
    localparam int POS_FUNC  = 1;
    localparam int FUNC_W    = 4;
    localparam int POS_BCON  = 5;
    localparam int POS_ABUS  = 6;
    localparam int POS_WE    = 7;
    localparam int POS_WSEL  = 8;
    localparam int POS_BFLD  = 9;
    localparam int BFLD_W    = 4;
    localparam int POS_AADR  = 13;
    localparam int AADR_W    = 3;
    localparam int POS_BEN   = 16;
    localparam int POS_BWR   = 17;
    localparam int USED_W    = 18;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic                store_flags;
        logic [FUNC_W-1:0]   alu_func;
        logic                b_is_const;
        logic                a_from_bus;
        logic                reg_we;
        logic                wr_to_b;
        logic [BFLD_W-1:0]   b_field;
        logic [AADR_W-1:0]   a_addr;
        bus_mode_e           bus_mode;
    } uop_t;
endpackage

// File: rtl/mpdc_decode.sv
module mpdc_decode
    import mpdc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output uop_t               uop_o
);
    logic unused_hi;
    assign unused_hi = ^instr_i[INSTR_W-1:USED_W];

    always_comb begin
        uop_o.store_flags = instr_i[POS_FLAG];
        uop_o.alu_func    = instr_i[POS_FUNC +: FUNC_W];
        uop_o.b_is_const  = instr_i[POS_BCON];
        uop_o.a_from_bus  = instr_i[POS_ABUS];
        uop_o.reg_we      = instr_i[POS_WE];
        uop_o.wr_to_b     = instr_i[POS_WSEL];
        uop_o.b_field     = instr_i[POS_BFLD +: BFLD_W];
        uop_o.a_addr      = instr_i[POS_AADR +: AADR_W];
        unique case ({instr_i[POS_BEN], instr_i[POS_BWR]})
            2'b10:   uop_o.bus_mode = BUS_READ;
            2'b11:   uop_o.bus_mode = BUS_WRITE;
            default: uop_o.bus_mode = BUS_IDLE;
        endcase
    end
endmodule

// File: rtl/mpdc_regfile.sv
module mpdc_regfile #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] raddr_a_i,
    input  logic [ADDR_W-1:0] raddr_b_i,
    output logic [DATA_W-1:0] rdata_a_o,
    output logic [DATA_W-1:0] rdata_b_o,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                regs[g] <= '0;
            end else if (we_i && (waddr_i == ADDR_W'(g))) begin
                regs[g] <= wdata_i;
            end
        end
    end

    assign rdata_a_o = regs[raddr_a_i];
    assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/mpdc_opmux.sv
module mpdc_opmux #(
    parameter int DATA_W  = 8,
    parameter int CONST_W = 4
) (
    input  logic [DATA_W-1:0]  reg_a_i,
    input  logic [DATA_W-1:0]  reg_b_i,
    input  logic [DATA_W-1:0]  bus_rdata_i,
    input  logic [CONST_W-1:0] const_i,
    input  logic               a_from_bus_i,
    input  logic               b_is_const_i,
    output logic [DATA_W-1:0]  op_a_o,
    output logic [DATA_W-1:0]  op_b_o
);
    localparam int EXT_W = DATA_W - CONST_W;

    logic [DATA_W-1:0] const_ext;
    assign const_ext = {{EXT_W{const_i[CONST_W-1]}}, const_i};

    assign op_a_o = a_from_bus_i ? bus_rdata_i : reg_a_i;
    assign op_b_o = b_is_const_i ? const_ext   : reg_b_i;
endmodule

// File: rtl/mpdc_top.sv
module mpdc_top
    import mpdc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  alu_result_i,
    input  logic [DATA_W-1:0]  bus_rdata_i,
    output logic [DATA_W-1:0]  alu_a_o,
    output logic [DATA_W-1:0]  alu_b_o,
    output logic [FUNC_W-1:0]  alu_func_o,
    output logic               store_flags_o,
    output logic [DATA_W-1:0]  bus_addr_o,
    output logic [DATA_W-1:0]  bus_wdata_o,
    output logic               bus_rd_o,
    output logic               bus_wr_o
);
    localparam int ADDR_W = AADR_W;

    uop_t              uop;
    logic [DATA_W-1:0] reg_a;
    logic [DATA_W-1:0] reg_b;
    logic [ADDR_W-1:0] waddr;

    mpdc_decode u_dec (
        .instr_i (instr_i),
        .uop_o   (uop)
    );

    assign waddr = uop.wr_to_b ? uop.b_field[ADDR_W-1:0] : uop.a_addr;

    mpdc_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .raddr_a_i (uop.a_addr),
        .raddr_b_i (uop.b_field[ADDR_W-1:0]),
        .rdata_a_o (reg_a),
        .rdata_b_o (reg_b),
        .we_i      (uop.reg_we),
        .waddr_i   (waddr),
        .wdata_i   (alu_result_i)
    );

    mpdc_opmux #(.DATA_W(DATA_W), .CONST_W(BFLD_W)) u_mux (
        .reg_a_i      (reg_a),
        .reg_b_i      (reg_b),
        .bus_rdata_i  (bus_rdata_i),
        .const_i      (uop.b_field),
        .a_from_bus_i (uop.a_from_bus),
        .b_is_const_i (uop.b_is_const),
        .op_a_o       (alu_a_o),
        .op_b_o       (alu_b_o)
    );

    assign alu_func_o    = uop.alu_func;
    assign store_flags_o = uop.store_flags;
    assign bus_addr_o    = reg_a;

    always_comb begin
        bus_rd_o    = 1'b0;
        bus_wr_o    = 1'b0;
        bus_wdata_o = '0;
        unique case (uop.bus_mode)
            BUS_READ: begin
                bus_rd_o = 1'b1;
            end
            BUS_WRITE: begin
                bus_wr_o    = 1'b1;
                bus_wdata_o = alu_result_i;
            end
            default: begin
                bus_rd_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mpdc_chk.sv
module mpdc_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic [24:0] instr_i,
    input logic [7:0]  alu_result_i,
    input logic [7:0]  bus_rdata_i,
    input logic [7:0]  alu_a_o,
    input logic [7:0]  alu_b_o,
    input logic [3:0]  alu_func_o,
    input logic        store_flags_o,
    input logic        bus_rd_o,
    input logic        bus_wr_o
);
    // R2
    const_sext_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        instr_i[5] |-> alu_b_o == {{4{instr_i[12]}}, instr_i[12:9]});

    // R3
    bus_operand_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        instr_i[6] |-> alu_a_o == bus_rdata_i);

    // R4
    write_visible_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(instr_i[7]) && !$past(instr_i[8]) && !instr_i[6]
         && instr_i[15:13] == $past(instr_i[15:13]))
        |-> alu_a_o == $past(alu_result_i));

    // R4
    no_write_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(instr_i[7]) && !$past(instr_i[6]) && !instr_i[6]
         && instr_i[15:13] == $past(instr_i[15:13]))
        |-> alu_a_o == $past(alu_a_o));

    // R6
    bus_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (instr_i[16] && instr_i[17]) |-> (bus_wr_o && !bus_rd_o));

    // R7
    bus_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (instr_i[16] && !instr_i[17]) |-> (bus_rd_o && !bus_wr_o));

    // R7
    bus_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !instr_i[16] |-> (!bus_rd_o && !bus_wr_o));

    // R9
    passthru_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (alu_func_o == instr_i[4:1]) && (store_flags_o == instr_i[0]));
endmodule

bind mpdc_top mpdc_chk u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .instr_i       (instr_i),
    .alu_result_i  (alu_result_i),
    .bus_rdata_i   (bus_rdata_i),
    .alu_a_o       (alu_a_o),
    .alu_b_o       (alu_b_o),
    .alu_func_o    (alu_func_o),
    .store_flags_o (store_flags_o),
    .bus_rd_o      (bus_rd_o),
    .bus_wr_o      (bus_wr_o)
);

// File: tb/mpdc_top_bench.sv
module mpdc_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [24:0] instr = '0;
    logic [7:0]  alu_res, rdata, alu_a, alu_b, bus_addr, bus_wdata;
    logic [3:0]  alu_func;
    logic        store_flags, bus_rd, bus_wr;

    always #5 clk = ~clk;

    mpdc_top u_mpdc_top (
        .clk_i (clk), .rst_i (rst), .instr_i (instr),
        .alu_result_i (alu_res), .bus_rdata_i (rdata),
        .alu_a_o (alu_a), .alu_b_o (alu_b), .alu_func_o (alu_func),
        .store_flags_o (store_flags), .bus_addr_o (bus_addr),
        .bus_wdata_o (bus_wdata), .bus_rd_o (bus_rd), .bus_wr_o (bus_wr)
    );

    // external ALU and bus memory
    logic [7:0] mem [256];
    assign alu_res = alu_a + alu_b;
    assign rdata   = mem[bus_addr];
    always @(posedge clk) if (bus_wr) mem[bus_addr] <= bus_wdata;

    // reference model
    logic [7:0] m_reg [8];
    logic [7:0] m_mem [256];

    typedef struct {
        logic [7:0] a, b, addr, wdata;
        logic [3:0] fn;
        logic       fl, rd, wr;
        string      tag;
    } item_t;
    item_t sbq [$];
    int n_run = 0, n_fail = 0;
    bit done = 0;

    function automatic logic [24:0] mk(input logic fl, input logic [3:0] fn,
        input logic bc, input logic ab, input logic we, input logic ws,
        input logic [3:0] bf, input logic [2:0] aa, input logic be, input logic bw);
        return {7'd0, bw, be, aa, bf, ws, we, ab, bc, fn, fl};
    endfunction

    task automatic issue(input logic [24:0] ins, input string tag);
        item_t it;
        logic [7:0] ra, res;
        @(negedge clk);
        instr = ins;
        ra       = m_reg[ins[15:13]];
        it.addr  = ra;
        it.a     = ins[6] ? m_mem[ra] : ra;
        it.b     = ins[5] ? {{4{ins[12]}}, ins[12:9]} : m_reg[ins[11:9]];
        res      = it.a + it.b;
        it.rd    = ins[16] & ~ins[17];
        it.wr    = ins[16] & ins[17];
        it.wdata = res;
        it.fn    = ins[4:1];
        it.fl    = ins[0];
        it.tag   = tag;
        sbq.push_back(it);
        if (it.wr) m_mem[ra] = res;
        if (ins[7]) m_reg[ins[8] ? ins[11:9] : ins[15:13]] = res;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        instr = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
    endtask

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: compares just before each rising edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #4;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                chk(it.tag, "alu_a", alu_a, it.a);
                chk(it.tag, "alu_b", alu_b, it.b);
                chk(it.tag, "bus_addr", bus_addr, it.addr);
                chk(it.tag, "strobes", {6'd0, bus_rd, bus_wr}, {6'd0, it.rd, it.wr});
                chk(it.tag, "func_flag", {3'd0, alu_func, store_flags}, {3'd0, it.fn, it.fl});
                if (it.wr) chk(it.tag, "bus_wdata", bus_wdata, it.wdata);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]   = 8'(i * 7 + 3);
            m_mem[i] = 8'(i * 7 + 3);
        end
        do_reset();
        // R1: every register reads zero on both ports
        for (int r = 0; r < 8; r++)
            issue(mk(0, 4'h0, 0, 0, 0, 0, {1'b0, 3'(r)}, 3'(r), 0, 0), "R1");
        // R2 R4: constant loads, positive and negative
        issue(mk(0, 4'h4, 1, 0, 1, 0, 4'h7, 3'd1, 0, 0), "R2");
        issue(mk(0, 4'h4, 1, 0, 1, 0, 4'h8, 3'd2, 0, 0), "R2");
        issue(mk(0, 4'h4, 1, 0, 1, 0, 4'hF, 3'd3, 0, 0), "R2");
        // R4: write to B address from registers
        issue(mk(0, 4'h4, 0, 0, 1, 1, 4'h2, 3'd1, 0, 0), "R4");
        // R2: constant bits double as the B write address (target 5)
        issue(mk(0, 4'h4, 1, 0, 1, 1, 4'hD, 3'd3, 0, 0), "R2");
        // R4: write disabled, then read target
        issue(mk(0, 4'h4, 0, 0, 0, 0, 4'h1, 3'd5, 0, 0), "R4");
        issue(mk(0, 4'h0, 0, 0, 0, 0, 4'h5, 3'd5, 0, 0), "R4");
        // R5: consecutive self-writes read old value
        issue(mk(0, 4'h4, 0, 0, 1, 0, 4'h1, 3'd1, 0, 0), "R5");
        issue(mk(0, 4'h4, 0, 0, 1, 0, 4'h1, 3'd1, 0, 0), "R5");
        issue(mk(0, 4'h0, 0, 0, 0, 0, 4'h1, 3'd1, 0, 0), "R5");
        // R3 R7: bus read as operand A, result into R0 via B address
        issue(mk(0, 4'h4, 1, 1, 1, 1, 4'h0, 3'd1, 1, 0), "R3");
        issue(mk(0, 4'h0, 0, 0, 0, 0, 4'h0, 3'd0, 0, 0), "R3");
        // R6 R8: bus write plus register write in one instruction
        issue(mk(0, 4'h4, 1, 0, 1, 0, 4'h1, 3'd3, 1, 1), "R8");
        issue(mk(0, 4'h4, 1, 1, 0, 0, 4'h0, 3'd2, 1, 0), "R6");
        issue(mk(0, 4'h0, 0, 0, 0, 0, 4'h3, 3'd3, 0, 0), "R8");
        // R7: bus write bit alone and bus operand without enable
        issue(mk(0, 4'h4, 0, 0, 0, 0, 4'h0, 3'd2, 0, 1), "R7");
        issue(mk(0, 4'h4, 0, 1, 0, 0, 4'h0, 3'd2, 0, 0), "R7");
        // R9: function and flag passthrough
        issue(mk(1, 4'hA, 0, 0, 0, 0, 4'h0, 3'd0, 0, 0), "R9");
        issue(mk(0, 4'h5, 1, 0, 0, 0, 4'h6, 3'd7, 0, 0), "R9");
        // R1: mid-run reset clears all registers
        do_reset();
        for (int r = 0; r < 8; r++)
            issue(mk(0, 4'h0, 0, 0, 0, 0, {1'b0, 3'(7 - r)}, 3'(r), 0, 0), "R1");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule